// File: doc/BRIEF.md
# Inline Codeword Correction Streamer

This block repairs a codeword while it passes through. A decoder elsewhere finds the error positions and the error patterns and loads them into the block through a small result port, together with a flag that says whether the word could be corrected at all. The same codeword is then streamed back in, one symbol per clock. Each symbol leaves the block exactly three clocks later, XORed with the stored pattern when its position matches a stored location.

Each outgoing symbol comes with four qualifiers:
- An active-low output-valid flag.
- A one-cycle header pulse on the first symbol of the word.
- A flag on symbols that were actually changed.
- A flag that separates information symbols from check symbols.

The position of a symbol is counted from zero at the header. The boundary between information and check symbols is taken from the code length and check length inputs.

The list holds up to `MAX_ERR` entries. It is cleared and armed with a start strobe, and it is filled by push strobes while no word is in flight.

Top module: `ecs_streamer`

## Requirements
- R1: While reset is asserted, and until the first symbol reaches the output, `act_n` is 1 and `dat_out`, `hdr_out`, `fix_out` and `info_out` are 0.
- R2: A symbol sampled with `vld_n`=0 in clock cycle c appears on `dat_out`, with its qualifiers, in cycle c+3.
- R3: `hdr_out` is 1 exactly in the output cycle of a symbol that was sampled with `hdr_in`=1 and `vld_n`=0. `hdr_in` is ignored while `vld_n`=1.
- R4: `act_n` is 0 exactly in output cycles that carry a valid symbol, and `dat_out` is 0 in the other cycles. A cycle with `vld_n`=1 does not advance the symbol position.
- R5: The position is 0 for a symbol that comes with the header, and is one more than the previous valid symbol otherwise (8-bit, wrapping). When the position equals a stored location, the output is the input XOR the stored value. If several stored entries match, all of their values are XORed in.
- R6: `fix_out` is 1 only when the output symbol differs from the input symbol. A matching entry whose value is zero leaves `fix_out` at 0.
- R7: `info_out` is 1 for valid symbols whose position is below `code_len - chk_len`, and 0 otherwise. When `chk_len >= code_len`, no symbol is an information symbol.
- R8: When the list was started with `res_uncorr`=1, every symbol passes unchanged with the same three-clock delay, and `fix_out` stays 0.
- R9: `res_start`=1 empties the list and latches `res_uncorr`; a push in that same cycle is ignored. Otherwise `res_push`=1 appends (`res_loc`, `res_val`). Pushes beyond `MAX_ERR` entries are ignored and have no effect on the output.
- R10: A header in the middle of a word restarts the position count at 0 for that symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 8 | Incoming codeword symbol |
| hdr_in | input | 1 | 1 with the first symbol of a word |
| vld_n | input | 1 | 0 when `sym_in` carries a valid symbol |
| code_len | input | 8 | Symbols per codeword |
| chk_len | input | 8 | Check symbols per codeword |
| res_start | input | 1 | Clear the list and latch `res_uncorr` |
| res_uncorr | input | 1 | 1 when the loaded word is uncorrectable |
| res_push | input | 1 | Append one location/value pair |
| res_loc | input | 8 | Error position to append |
| res_val | input | 8 | Error pattern to append |
| dat_out | output | 8 | Corrected symbol |
| hdr_out | output | 1 | Head-symbol pulse |
| act_n | output | 1 | 0 while a corrected symbol is output |
| fix_out | output | 1 | 1 when the output symbol was modified |
| info_out | output | 1 | 1 for information symbols |

## Verification
Every result is due three clocks after its input symbol: data, header pulse, active flag, fix flag and information flag all emerge together from the same third register. List loads take effect one clock after their strobe. The bench keeps its own model of the position count and the list. It queues each cycle's expected outputs into a three-deep delay line and compares all five outputs in the falling-edge half of each cycle against the entry from three cycles earlier, so gaps, header restarts and idle cycles are all checked at their exact output cycle.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  // Qualifiers that travel with a symbol through the pipeline
  typedef struct packed {
    logic vld;
    logic hdr;
    logic info;
  } ecs_tag_t;

endpackage

// File: rtl/ecs_index.sv
module ecs_index
  import ecs_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             hdr_in,
  input  logic             vld_n,
  input  logic [IDX_W-1:0] code_len,
  input  logic [IDX_W-1:0] chk_len,
  output logic [SYM_W-1:0] s1_sym,
  output ecs_tag_t         s1_tag,
  output logic [IDX_W-1:0] s1_idx
);

  logic             take;
  logic             head;
  logic [IDX_W-1:0] idx_now;
  logic [IDX_W:0]   info_lim;
  logic             info_now;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [SYM_W-1:0] sym_d;
  logic [IDX_W-1:0] idx_d;
  ecs_tag_t         tag_d;

  always_comb begin
    take    = ~vld_n;
    head    = take & hdr_in;
    idx_now = head ? '0 : cnt_q;
    if (chk_len >= code_len) info_lim = '0;
    else                     info_lim = {1'b0, code_len} - {1'b0, chk_len};
    info_now = take && ({1'b0, idx_now} < info_lim);
    cnt_d    = take ? idx_now + 1'b1 : cnt_q;
    sym_d    = take ? sym_in : s1_sym;
    idx_d    = take ? idx_now : s1_idx;
    tag_d.vld  = take;
    tag_d.hdr  = head;
    tag_d.info = info_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      s1_sym <= '0;
      s1_idx <= '0;
      s1_tag <= '0;
    end else begin
      cnt_q  <= cnt_d;
      s1_sym <= sym_d;
      s1_idx <= idx_d;
      s1_tag <= tag_d;
    end
  end

  // R10
  hdr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_n && hdr_in) |=> (s1_idx == '0 && s1_tag.hdr));

  // R4
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_n |=> (!s1_tag.vld && $stable(cnt_q)));

endmodule

// File: rtl/ecs_list.sv
module ecs_list #(
  parameter int SYM_W   = 8,
  parameter int IDX_W   = 8,
  parameter int MAX_ERR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_start,
  input  logic             res_uncorr,
  input  logic             res_push,
  input  logic [IDX_W-1:0] res_loc,
  input  logic [SYM_W-1:0] res_val,
  input  logic [IDX_W-1:0] probe_idx,
  output logic [SYM_W-1:0] hit_mask,
  output logic             uncorr
);

  localparam int CNT_W = $clog2(MAX_ERR + 1);
  localparam int IX_W  = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  logic [IDX_W-1:0] loc_q [MAX_ERR];
  logic [IDX_W-1:0] loc_d [MAX_ERR];
  logic [SYM_W-1:0] val_q [MAX_ERR];
  logic [SYM_W-1:0] val_d [MAX_ERR];
  logic [SYM_W-1:0] term  [MAX_ERR];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             unc_q, unc_d;
  logic             room;

  always_comb begin
    loc_d = loc_q;
    val_d = val_q;
    cnt_d = cnt_q;
    unc_d = unc_q;
    room  = cnt_q < CNT_W'(MAX_ERR);
    if (res_start) begin
      cnt_d = '0;
      unc_d = res_uncorr;
    end else if (res_push && room) begin
      loc_d[cnt_q[IX_W-1:0]] = res_loc;
      val_d[cnt_q[IX_W-1:0]] = res_val;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_ERR; i++) begin
        loc_q[i] <= '0;
        val_q[i] <= '0;
      end
      cnt_q <= '0;
      unc_q <= 1'b0;
    end else begin
      loc_q <= loc_d;
      val_q <= val_d;
      cnt_q <= cnt_d;
      unc_q <= unc_d;
    end
  end

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_ent
    assign term[g] = ((CNT_W'(g) < cnt_q) && (loc_q[g] == probe_idx)) ? val_q[g] : '0;
  end

  always_comb begin
    hit_mask = '0;
    for (int i = 0; i < MAX_ERR; i++) hit_mask = hit_mask ^ term[i];
  end

  assign uncorr = unc_q;

  // R9
  list_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_ERR));

  // R9
  list_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_start |=> (cnt_q == '0 && hit_mask == '0 && uncorr == $past(res_uncorr)));

endmodule

// File: rtl/ecs_apply.sv
module ecs_apply
  import ecs_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] s1_sym,
  input  ecs_tag_t         s1_tag,
  input  logic [SYM_W-1:0] hit_mask,
  input  logic             uncorr,
  output logic [SYM_W-1:0] dat_out,
  output logic             hdr_out,
  output logic             act_n,
  output logic             fix_out,
  output logic             info_out
);

  logic [SYM_W-1:0] s2_sym_q, s2_sym_d;
  logic [SYM_W-1:0] s2_msk_q, s2_msk_d;
  ecs_tag_t         s2_tag_q, s2_tag_d;
  logic [SYM_W-1:0] dat_d;
  logic             hdr_d, act_n_d, fix_d, info_d;

  always_comb begin
    s2_sym_d = s1_tag.vld ? s1_sym : s2_sym_q;
    s2_msk_d = (s1_tag.vld && !uncorr) ? hit_mask : '0;
    s2_tag_d = s1_tag;
    dat_d    = s2_tag_q.vld ? (s2_sym_q ^ s2_msk_q) : '0;
    fix_d    = s2_tag_q.vld && (|s2_msk_q);
    act_n_d  = ~s2_tag_q.vld;
    hdr_d    = s2_tag_q.vld && s2_tag_q.hdr;
    info_d   = s2_tag_q.vld && s2_tag_q.info;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_sym_q <= '0;
      s2_msk_q <= '0;
      s2_tag_q <= '0;
      dat_out  <= '0;
      hdr_out  <= 1'b0;
      act_n    <= 1'b1;
      fix_out  <= 1'b0;
      info_out <= 1'b0;
    end else begin
      s2_sym_q <= s2_sym_d;
      s2_msk_q <= s2_msk_d;
      s2_tag_q <= s2_tag_d;
      dat_out  <= dat_d;
      hdr_out  <= hdr_d;
      act_n    <= act_n_d;
      fix_out  <= fix_d;
      info_out <= info_d;
    end
  end

  // R6
  fix_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_out |-> !act_n);

  // R8
  uncorr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_tag.vld && uncorr) |=> ##1 (!fix_out && dat_out == $past(s1_sym, 2)));

  // R7
  info_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    info_out |-> !act_n);

endmodule

// File: rtl/ecs_streamer.sv
module ecs_streamer
  import ecs_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int IDX_W   = 8,
  parameter int MAX_ERR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             hdr_in,
  input  logic             vld_n,
  input  logic [IDX_W-1:0] code_len,
  input  logic [IDX_W-1:0] chk_len,
  input  logic             res_start,
  input  logic             res_uncorr,
  input  logic             res_push,
  input  logic [IDX_W-1:0] res_loc,
  input  logic [SYM_W-1:0] res_val,
  output logic [SYM_W-1:0] dat_out,
  output logic             hdr_out,
  output logic             act_n,
  output logic             fix_out,
  output logic             info_out
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SYM_W-1:0] s1_sym;
  ecs_tag_t         s1_tag;
  logic [IDX_W-1:0] s1_idx;
  logic [SYM_W-1:0] hit_mask;
  logic             uncorr;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ecs_index #(.SYM_W(SYM_W), .IDX_W(IDX_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sym_in   (sym_in),
    .hdr_in   (hdr_in),
    .vld_n    (vld_n),
    .code_len (code_len),
    .chk_len  (chk_len),
    .s1_sym   (s1_sym),
    .s1_tag   (s1_tag),
    .s1_idx   (s1_idx)
  );

  ecs_list #(.SYM_W(SYM_W), .IDX_W(IDX_W), .MAX_ERR(MAX_ERR)) u_list (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .res_start  (res_start),
    .res_uncorr (res_uncorr),
    .res_push   (res_push),
    .res_loc    (res_loc),
    .res_val    (res_val),
    .probe_idx  (s1_idx),
    .hit_mask   (hit_mask),
    .uncorr     (uncorr)
  );

  ecs_apply #(.SYM_W(SYM_W)) u_apply (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .s1_sym   (s1_sym),
    .s1_tag   (s1_tag),
    .hit_mask (hit_mask),
    .uncorr   (uncorr),
    .dat_out  (dat_out),
    .hdr_out  (hdr_out),
    .act_n    (act_n),
    .fix_out  (fix_out),
    .info_out (info_out)
  );

  // R2
  lat_active_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !vld_n |=> ##2 !act_n);

  // R4
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    vld_n |=> ##2 (act_n && dat_out == '0 && !hdr_out));

  // R3
  lat_head_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!vld_n && hdr_in) |=> ##2 hdr_out);

endmodule

// File: tb/ecs_streamer_test.sv
module ecs_streamer_test;

  localparam int MAXE = 8;

  typedef struct packed {
    logic [7:0] dat;
    logic       hdr;
    logic       act_n;
    logic       fix;
    logic       info;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [7:0] sym_in;
  logic       hdr_in;
  logic       vld_n;
  logic [7:0] code_len;
  logic [7:0] chk_len;
  logic       res_start;
  logic       res_uncorr;
  logic       res_push;
  logic [7:0] res_loc;
  logic [7:0] res_val;
  logic [7:0] dat_out;
  logic       hdr_out;
  logic       act_n;
  logic       fix_out;
  logic       info_out;

  int   n_chk;
  int   n_fail;
  bit   done;
  exp_t p0, p1, p2;

  // Bench model of the list and the position counter
  logic [7:0] m_loc [MAXE];
  logic [7:0] m_val [MAXE];
  int         m_cnt;
  bit         m_unc;
  logic [7:0] m_idx;

  ecs_streamer uut (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .hdr_in(hdr_in), .vld_n(vld_n),
    .code_len(code_len), .chk_len(chk_len), .res_start(res_start),
    .res_uncorr(res_uncorr), .res_push(res_push), .res_loc(res_loc),
    .res_val(res_val), .dat_out(dat_out), .hdr_out(hdr_out), .act_n(act_n),
    .fix_out(fix_out), .info_out(info_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cmp(string req, string what, logic [7:0] got, logic [7:0] want);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, got, want, $time);
    end
  endtask

  task automatic check_out(exp_t e, string tag);
    cmp({tag, " R2/R5"}, "dat_out", dat_out, e.dat);
    cmp({tag, " R3"}, "hdr_out", {7'd0, hdr_out}, {7'd0, e.hdr});
    cmp({tag, " R4"}, "act_n", {7'd0, act_n}, {7'd0, e.act_n});
    cmp({tag, " R6"}, "fix_out", {7'd0, fix_out}, {7'd0, e.fix});
    cmp({tag, " R7"}, "info_out", {7'd0, info_out}, {7'd0, e.info});
  endtask

  // One clock: model the driven inputs, advance, compare with the symbol of three cycles ago
  task automatic tick(string tag);
    exp_t       e;
    logic [7:0] idx;
    logic [7:0] mask;
    int         lim;
    e = '0;
    e.act_n = 1'b1;
    if (!vld_n) begin
      idx   = hdr_in ? 8'd0 : m_idx;
      m_idx = idx + 8'd1;
      mask  = 8'd0;
      if (!m_unc)
        for (int j = 0; j < m_cnt; j++)
          if (m_loc[j] == idx) mask = mask ^ m_val[j];
      lim     = (int'(chk_len) >= int'(code_len)) ? 0 : int'(code_len) - int'(chk_len);
      e.act_n = 1'b0;
      e.dat   = sym_in ^ mask;
      e.hdr   = hdr_in;
      e.fix   = (mask != 8'd0);
      e.info  = (int'(idx) < lim);
    end
    if (res_start) begin
      m_cnt = 0;
      m_unc = res_uncorr;
    end else if (res_push && m_cnt < MAXE) begin
      m_loc[m_cnt] = res_loc;
      m_val[m_cnt] = res_val;
      m_cnt++;
    end
    p2 = p1;
    p1 = p0;
    p0 = e;
    @(posedge clk);
    @(negedge clk);
    check_out(p2, tag);
    res_start = 1'b0;
    res_push  = 1'b0;
    vld_n     = 1'b1;
    hdr_in    = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic start_list(bit unc);
    res_start  = 1'b1;
    res_uncorr = unc;
    tick("load R9");
  endtask

  task automatic push(logic [7:0] loc, logic [7:0] val);
    res_push = 1'b1;
    res_loc  = loc;
    res_val  = val;
    tick("load R9");
  endtask

  task automatic send(logic [7:0] s, bit h, string tag);
    sym_in = s;
    hdr_in = h;
    vld_n  = 1'b0;
    tick(tag);
  endtask

  task automatic send_word(int n, int seed, string tag);
    for (int i = 0; i < n; i++) send(8'(i * 37 + seed), (i == 0), tag);
    idle(3, tag);
  endtask

  task automatic sc_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1", "act_n in reset", {7'd0, act_n}, 8'd1);
    cmp("R1", "dat_out in reset", dat_out, 8'd0);
    cmp("R1", "flags in reset", {4'd0, hdr_out, fix_out, info_out, 1'b0}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1", "act_n after reset", {7'd0, act_n}, 8'd1);
    cmp("R1", "dat_out after reset", dat_out, 8'd0);
  endtask

  task automatic sc_clean();
    code_len = 8'd10;
    chk_len  = 8'd4;
    start_list(1'b0);
    idle(2, "clean R2");
    send_word(10, 5, "clean R2");
  endtask

  task automatic sc_fix();
    start_list(1'b0);
    push(8'd2, 8'h5A);
    push(8'd7, 8'h81);
    push(8'd4, 8'h00);
    push(8'd7, 8'h0F);
    idle(2, "fix R5");
    send_word(10, 11, "fix R5 R6");
  endtask

  task automatic sc_gaps();
    for (int i = 0; i < 10; i++) begin
      send(8'(i * 13 + 1), (i == 0), "gaps R4");
      if (i % 3 == 1) idle(2, "gaps R4");
    end
    idle(3, "gaps R4");
  endtask

  task automatic sc_uncorr();
    start_list(1'b1);
    push(8'd3, 8'hFF);
    push(8'd0, 8'h01);
    idle(2, "unc R8");
    send_word(10, 200, "unc R8");
  endtask

  task automatic sc_overflow();
    start_list(1'b0);
    for (int i = 0; i <= MAXE; i++) push(8'(i), 8'(i + 1));
    idle(2, "ovf R9");
    send_word(10, 77, "ovf R9");
  endtask

  task automatic sc_rehead();
    start_list(1'b0);
    push(8'd1, 8'h11);
    idle(2, "rehead R10");
    send(8'hA0, 1'b1, "rehead R10");
    send(8'hA1, 1'b0, "rehead R10");
    send(8'hA2, 1'b0, "rehead R10");
    send(8'hA3, 1'b1, "rehead R10");
    send(8'hA4, 1'b0, "rehead R10");
    vld_n  = 1'b1;
    hdr_in = 1'b1;
    tick("rehead R3");
    send(8'hA5, 1'b0, "rehead R10");
    idle(3, "rehead R10");
  endtask

  task automatic sc_bounds();
    chk_len = 8'd10;
    send_word(6, 3, "bound R7");
    chk_len = 8'd12;
    send_word(4, 9, "bound R7");
    chk_len = 8'd0;
    send_word(10, 21, "bound R7");
    chk_len = 8'd4;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    sym_in = '0; hdr_in = 1'b0; vld_n = 1'b1;
    code_len = 8'd10; chk_len = 8'd4;
    res_start = 1'b0; res_uncorr = 1'b0; res_push = 1'b0;
    res_loc = '0; res_val = '0;
    m_cnt = 0; m_unc = 1'b0; m_idx = 8'd0;
    for (int i = 0; i < MAXE; i++) begin m_loc[i] = '0; m_val[i] = '0; end
    p0 = '0; p0.act_n = 1'b1;
    p1 = p0; p2 = p0;
    sc_reset();
    sc_clean();
    sc_fix();
    sc_gaps();
    sc_uncorr();
    sc_overflow();
    sc_rehead();
    sc_bounds();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule